// File: doc/BRIEF.md
# Power-Down Sequencer with Configuration Strap Capture

This block orders the entry into and the exit from a low-power state for a clock generator, and it captures configuration straps at power-on. While power-on reset is held, a set of shared pads acts as inputs. Their levels are taken into a strap latch on every clock. On reset release the latch freezes and the pads are handed over to clock-output duty. The latched values are offered in inverted form for register readback.

An active-low power-down request arrives asynchronously and passes through a two-stage synchronizer. The sequencer then withdraws the enable of every output group. Each output stage finishes its current cycle, holds low and returns a parked flag. Only when every group reports parked are the crystal oscillator and the PLL turned off. A slow group, such as a reference output, may take several of its own cycles to park, and the sequencer waits for it however long that takes.

When the request is released, both analog blocks are restarted. A settle counter of system clocks must expire before the outputs are enabled again. The CPU and PCI stop inputs gate their groups only while the block is running, and they have no effect at any other time. Both analog blocks are modelled as enable signals.

Top module: `pwrdn_seq`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 0 and the strap latch follows `strap_pin_i`. From the first rising edge with `rst_n` high, `pin_oe` is 1 and `strap_rb` equals the bitwise inverse of `strap_pin_i` as sampled at the last edge of reset. `strap_rb` then ignores all later changes on `strap_pin_i`.
- R2: `pd_n` is synchronized by two flops. If `pd_n` goes low after rising edge k−1 and is held low, the running state is left at edge k+2. The same latency applies when `pd_n` is released.
- R3: In every state other than running, all bits of `out_en` are 0.
- R4: In the parking state, `osc_en` and `pll_en` stay 1 until all bits of `parked_i` are 1 at a rising edge. At that edge the block enters the off state, where both are 0.
- R5: The off state is held while the synchronized request is active. At the first edge after the request is seen released, the block enters waking with `osc_en` and `pll_en` at 1.
- R6: Waking lasts exactly SETTLE_CYC clocks. The block then returns to running with its outputs enabled.
- R7: If `pd_n` is released during parking, parking still completes. The block passes through the off state for at least one clock, then wakes normally.
- R8: While running, `out_en[0]` equals `stop_cpu_n`, `out_en[1]` equals `stop_pci_n`, and the other bits are 1. Outside the running state, both stop inputs have no effect.
- R9: `status` encodes the state as 0 = running, 1 = parking, 2 = off, 3 = waking.
- R10: A new power-down request during waking does not cut the settle period short. After waking completes, the block enters running and then parking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous; the strap sampling window |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| stop_cpu_n | input | 1 | CPU group stop, active low, effective only while running |
| stop_pci_n | input | 1 | PCI group stop, active low, effective only while running |
| strap_pin_i | input | STRAP_W | Levels seen on the shared pads |
| parked_i | input | NOUT | Per-group flag: output is low and held |
| pin_oe | output | 1 | Shared pads driven as outputs |
| strap_rb | output | STRAP_W | Inverted latched strap values |
| out_en | output | NOUT | Per-group run enable |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL/VCO enable |
| status | output | 2 | Sequencer state code |

## Verification
Two events can fall in the same clock: the release of `pd_n` and the arrival of the last parked flag. The bench provokes this by releasing `pd_n` while the slow group is still parking. It then checks that the off state still appears for one clock before waking (R7). A second collision occurs when a fresh request lands inside the settle window. Here the bench checks that waking keeps its full length before parking begins (R10). Long random runs toggle `pd_n` and both stop inputs at arbitrary moments, so these overlaps also arise at many other phases. Every cycle is judged against a cycle-level model of the sequence.

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int NOUT       = 4,
  parameter int STRAP_W    = 5,
  parameter int SETTLE_CYC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic               stop_cpu_n,
  input  logic               stop_pci_n,
  input  logic [STRAP_W-1:0] strap_pin_i,
  input  logic [NOUT-1:0]    parked_i,
  output logic               pin_oe,
  output logic [STRAP_W-1:0] strap_rb,
  output logic [NOUT-1:0]    out_en,
  output logic               osc_en,
  output logic               pll_en,
  output logic [1:0]         status
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_PARK = 2'd1, S_OFF = 2'd2, S_WAKE = 2'd3} st_t;

  st_t              st;
  logic [1:0]       sync;
  logic [CNT_W-1:0] cnt;
  logic [STRAP_W-1:0] strap_q;

  wire req_live  = ~sync[1];
  wire all_park  = &parked_i;
  wire running   = (st == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_pin_i;
      pin_oe  <= 1'b0;
      sync    <= 2'b11;
      st      <= S_RUN;
      cnt     <= '0;
    end else begin
      pin_oe <= 1'b1;
      sync   <= {sync[0], pd_n};
      case (st)
        S_RUN:  if (req_live) st <= S_PARK;
        S_PARK: if (all_park) st <= S_OFF;
        S_OFF:  if (!req_live) begin
                  st  <= S_WAKE;
                  cnt <= '0;
                end
        S_WAKE: if (cnt == CNT_LAST) st <= S_RUN;
                else cnt <= cnt + 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_en
    if (i == 0) begin : g_cpu
      assign out_en[i] = running & stop_cpu_n;
    end else if (i == 1) begin : g_pci
      assign out_en[i] = running & stop_pci_n;
    end else begin : g_free
      assign out_en[i] = running;
    end
  end

  assign strap_rb = ~strap_q;
  assign osc_en   = (st != S_OFF);
  assign pll_en   = (st != S_OFF);
  assign status   = st;
endmodule

module pwrdn_seq_chk #(
  parameter int NOUT    = 4,
  parameter int STRAP_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NOUT-1:0]    parked_i,
  input logic [NOUT-1:0]    out_en,
  input logic               osc_en,
  input logic               pll_en,
  input logic               pin_oe,
  input logic [STRAP_W-1:0] strap_rb,
  input logic [1:0]         status
);
  assert_pins_stay_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |=> pin_oe);
  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |=> $stable(strap_rb));
  assert_dark_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0) |-> (out_en == '0));
  assert_osc_off_after_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(&parked_i));
  assert_park_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && !(&parked_i)) |=> (status == 2'd1 && osc_en && pll_en));
  assert_wake_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3) |-> (osc_en && pll_en));
  assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3) |=> (status == 2'd3 || status == 2'd0));
  assert_off_after_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1) |=> (status == 2'd1 || status == 2'd2));
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.NOUT(NOUT), .STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .parked_i(parked_i), .out_en(out_en),
  .osc_en(osc_en), .pll_en(pll_en), .pin_oe(pin_oe), .strap_rb(strap_rb),
  .status(status)
);

// File: tb/pwrdn_seq_test.sv
`timescale 1ns/1ps
module pwrdn_seq_test;
  localparam int NOUT = 4, SW = 5, SETTLE = 64;

  logic clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1, stop_cpu_n = 1'b1, stop_pci_n = 1'b1;
  logic [SW-1:0] strap_pin = 5'b10110;
  logic [NOUT-1:0] parked, out_en;
  logic pin_oe, osc_en, pll_en;
  logic [SW-1:0] strap_rb;
  logic [1:0] status;

  int unsigned total = 0, bad = 0, cyc = 0;
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  pwrdn_seq uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .stop_cpu_n(stop_cpu_n), .stop_pci_n(stop_pci_n),
    .strap_pin_i(strap_pin), .parked_i(parked), .pin_oe(pin_oe), .strap_rb(strap_rb),
    .out_en(out_en), .osc_en(osc_en), .pll_en(pll_en), .status(status)
  );

  // output stage model: group i toggles every DIV[i] clocks, parks once low
  int unsigned div_of [NOUT] = '{1, 2, 3, 7};
  logic [NOUT-1:0] lvl;
  int unsigned ocnt [NOUT];
  always @(posedge clk) begin
    for (int i = 0; i < NOUT; i++) begin
      if (!rst_n) begin
        lvl[i] <= 1'b0; ocnt[i] <= 0;
      end else if (out_en[i] || lvl[i]) begin
        if (ocnt[i] + 1 >= div_of[i]) begin lvl[i] <= ~lvl[i]; ocnt[i] <= 0; end
        else ocnt[i] <= ocnt[i] + 1;
      end
    end
  end
  for (genvar g = 0; g < NOUT; g++) begin : g_pk
    assign parked[g] = !out_en[g] && !lvl[g];
  end

  // sequence model built from the requirements
  logic [1:0] m_sync, m_st;
  int unsigned m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync <= 2'b11; m_st <= 2'd0; m_cnt <= 0;
    end else begin
      m_sync <= {m_sync[0], pd_n};
      case (m_st)
        2'd0: if (!m_sync[1]) m_st <= 2'd1;
        2'd1: if (&parked) m_st <= 2'd2;
        2'd2: if (m_sync[1]) begin m_st <= 2'd3; m_cnt <= 0; end
        default: if (m_cnt == SETTLE - 1) m_st <= 2'd0; else m_cnt <= m_cnt + 1;
      endcase
    end
  end

  function automatic logic [NOUT-1:0] exp_en(input logic [1:0] st, input logic c, input logic p);
    logic [NOUT-1:0] e;
    e = (st == 2'd0) ? '1 : '0;
    if (st == 2'd0) begin e[0] = c; e[1] = p; end
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on && rst_n) begin
      chk(status == m_st, "R9 status code", status, m_st);
      chk(out_en == exp_en(m_st, stop_cpu_n, stop_pci_n), "R3 R8 out_en", out_en,
          exp_en(m_st, stop_cpu_n, stop_pci_n));
      chk(osc_en == (m_st != 2'd2) && pll_en == (m_st != 2'd2), "R4 R5 osc_pll",
          {osc_en, pll_en}, (m_st != 2'd2) ? 3 : 0);
    end
  end

  task automatic wait_st(input logic [1:0] s, input string tag);
    int n = 0;
    while (status != s && n < 2000) begin @(negedge clk); n++; end
    chk(status == s, tag, status, s);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd7);
    repeat (4) @(negedge clk);
    chk(pin_oe == 1'b0, "R1 pads are inputs in reset", pin_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin_oe == 1'b1, "R1 pads become outputs", pin_oe, 1);
    chk(strap_rb == ~5'b10110, "R1 inverted strap", strap_rb, ~5'b10110);
    chk(status == 2'd0, "R9 reset state running", status, 0);
    strap_pin = 5'b01011;
    repeat (3) @(negedge clk);
    chk(strap_rb == ~5'b10110, "R1 strap frozen", strap_rb, ~5'b10110);
    mon_on = 1'b1;

    // R2 latency
    pd_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(status == 2'd0, "R2 still running after two edges", status, 0);
    @(negedge clk);
    chk(status == 2'd1, "R2 parking after third edge", status, 1);
    // R8 stops ignored during parking/off
    stop_cpu_n = 1'b0; stop_pci_n = 1'b1;
    wait_st(2'd2, "R4 reaches off");
    stop_cpu_n = 1'b1; stop_pci_n = 1'b0;
    @(negedge clk);
    chk(out_en == '0, "R8 stops ignored when off", out_en, 0);
    stop_pci_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(status == 2'd2, "R5 off held", status, 2);
    pd_n = 1'b1;
    wait_st(2'd3, "R5 waking");
    begin
      int n = 0;
      while (status == 2'd3 && n < 1000) begin @(negedge clk); n++; end
      chk(n == SETTLE, "R6 settle length", n, SETTLE);
    end
    chk(status == 2'd0, "R6 back to running", status, 0);
    chk(out_en == '1, "R6 outputs enabled", out_en, 15);

    // R7 release during parking
    repeat (10) @(negedge clk);
    pd_n = 1'b0;
    wait_st(2'd1, "R7 parking");
    pd_n = 1'b1;
    wait_st(2'd2, "R7 passes through off");
    @(negedge clk);
    chk(status == 2'd2 || status == 2'd3, "R7 clean restart", status, 3);
    wait_st(2'd3, "R7 wakes");

    // R10 request during waking
    repeat (4) @(negedge clk);
    pd_n = 1'b0;
    begin
      int n = 0;
      while (status == 2'd3 && n < 1000) begin @(negedge clk); n++; end
      chk(status == 2'd0, "R10 settle completes first", status, 0);
    end
    wait_st(2'd1, "R10 then parking");
    pd_n = 1'b1;
    wait_st(2'd0, "R10 recovers");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 59) == 0) pd_n = ~pd_n;
      if ($urandom_range(0, 7) == 0) stop_cpu_n = ~stop_cpu_n;
      if ($urandom_range(0, 7) == 0) stop_pci_n = ~stop_pci_n;
    end
    pd_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(status == 2'd0, "R6 ends running", status, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog R6 actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule